// File: doc/BRIEF.md
# Stage Stall and Squash Controller

This block governs the flow of one backend pipeline stage. Each cycle the upstream stage may present one opaque instruction bundle. The controller either passes that bundle straight on to the stage datapath, or holds it in a small skid buffer when the stage cannot take it. Two things stop the stage: a stall request from the downstream commit stage, or the instruction queue reporting that it is full. It also reacts to the two squash indications from downstream. One marks a squash request and the other marks a reorder buffer that is still squashing.

The status machine has five states. Idle and Running pass bundles through. Blocked stalls the upstream stage and captures whatever still arrives. Unblocking replays the captured bundles one per cycle, oldest first. It keeps the upstream stall raised until the last captured bundle goes out. Squashing drops all captured work and waits until both squash indications are gone. The datapath is enabled only in the states that can issue. A sticky flag reports any bundle lost because the skid buffer was full.

Top module: `stall_squash_ctrl`

## Requirements
- R1: After reset, status is Idle (code 0), runEn is 1, upStall is 0 and overflowErr is 0. The status codes are Idle=0, Running=1, Blocked=2, Unblocking=3 and Squashing=4.
- R2: In Idle or Running, with no stall, no squash and no queue-full condition, issueValid equals upValid in the same cycle and issueBundle equals upBundle. A dispatched valid bundle moves the status to Running.
- R3: In Idle, Running or Unblocking, a downstream stall wins over everything else, including a squash. In that cycle nothing issues, upStall is 1, a valid upstream bundle is captured, and the next status is Blocked.
- R4: In Idle, Running or Unblocking, iqFull while there is work to issue (a valid upstream bundle, or captured entries in Unblocking) has the same effect as a stall. iqFull with no work does not change the status.
- R5: In Blocked, upStall is 1 every cycle, runEn is 0 and valid upstream bundles are captured. The status moves to Unblocking in the cycle after one in which dnStall and iqFull are both low.
- R6: In Unblocking with captured entries, one entry issues per cycle in arrival order. upStall stays 1 while more than one entry remains before the pop. The status becomes Running once the buffer is empty.
- R7: A squash indication (dnSquash or dnRobSquash) without a downstream stall, seen in Idle, Running, Unblocking or Blocked, suppresses issue in that cycle. It moves the status to Squashing and discards every captured entry.
- R8: In Squashing, runEn, upStall and issueValid are 0 and upstream bundles are dropped. The status stays Squashing while either squash indication is high and becomes Running in the cycle after both are low.
- R9: A bundle captured while the skid buffer holds DEPTH entries (and none leaves) is dropped. overflowErr then rises and stays 1 until reset.
- R10: runEn is 1 exactly in Idle, Running and Unblocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upValid | input | 1 | Upstream bundle present |
| upBundle | input | BUNDLE_W | Upstream bundle payload |
| dnStall | input | 1 | Stall request from downstream commit |
| dnSquash | input | 1 | Squash request from downstream |
| dnRobSquash | input | 1 | Reorder buffer still squashing |
| iqFull | input | 1 | Instruction queue has no free entry |
| upStall | output | 1 | Stall to the upstream stage |
| runEn | output | 1 | Stage datapath enable |
| issueValid | output | 1 | A bundle issues to the datapath this cycle |
| issueBundle | output | BUNDLE_W | Bundle issued (live or replayed) |
| status | output | 3 | Current status code |
| overflowErr | output | 1 | Sticky skid overflow flag |

## Verification
The bench fills the skid buffer with every count from one to its full depth. It then checks the replay order and the exact cycle in which upStall drops; a controller that releases the stall one pop early or late fails there. It overfills the buffer by one bundle, which exposes a design that wraps over the oldest entry or forgets the sticky error. It raises a squash while entries are held and then replays a fresh capture, so a buffer left uncleared shows up as stale data issuing first. It also drives stall and squash together and stalls in the middle of a drain, which catches a wrong priority between stall, squash and dispatch.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_BLOCK   = 3'd2,
    ST_UNBLOCK = 3'd3,
    ST_SQUASH  = 3'd4
  } stageState_e;

  // Strobes from control to the skid datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
    logic selSkid;
  } skidCmd_t;

endpackage

// File: rtl/ssc_skid.sv
module ssc_skid
  import ssc_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int BUNDLE_W = 16,
  localparam int PTRW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  skidCmd_t            cmd,
  input  logic [BUNDLE_W-1:0] upBundle,
  output logic [CNTW-1:0]     skidCount,
  output logic [BUNDLE_W-1:0] issueBundle,
  output logic                overflowErr
);

  logic [BUNDLE_W-1:0] mem [DEPTH];
  logic [PTRW-1:0]     rdPtr, wrPtr;
  logic                isFull, pushEff, popEff, dropPush;

  assign isFull   = (skidCount == CNTW'(DEPTH));
  assign popEff   = cmd.pop && (skidCount != '0);
  assign pushEff  = cmd.push && (!isFull || popEff);
  assign dropPush = cmd.push && isFull && !popEff;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + PTRW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clear) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      skidCount <= '0;
    end else begin
      if (pushEff) wrPtr <= bump(wrPtr);
      if (popEff)  rdPtr <= bump(rdPtr);
      case ({pushEff, popEff})
        2'b10:   skidCount <= skidCount + CNTW'(1);
        2'b01:   skidCount <= skidCount - CNTW'(1);
        default: skidCount <= skidCount;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) mem[i] <= '0;
        else if (pushEff && !cmd.clear && wrPtr == PTRW'(i)) mem[i] <= upBundle;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)         overflowErr <= 1'b0;
    else if (dropPush) overflowErr <= 1'b1;
  end

  assign issueBundle = cmd.selSkid ? mem[rdPtr] : upBundle;

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (skidCount == '0));

  // R6
  pop_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEff && !cmd.push && !cmd.clear) |=> (skidCount == $past(skidCount) - CNTW'(1)));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    skidCount <= CNTW'(DEPTH));

endmodule

// File: rtl/ssc_control.sv
module ssc_control
  import ssc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            upValid,
  input  logic            dnStall,
  input  logic            dnSquash,
  input  logic            dnRobSquash,
  input  logic            iqFull,
  input  logic [CNTW-1:0] skidCount,
  output skidCmd_t        cmd,
  output logic            upStall,
  output logic            runEn,
  output logic            issueValid,
  output stageState_e     state
);

  stageState_e nextState;
  logic anySquash, runElig, drainMode, haveWork;

  assign anySquash = dnSquash || dnRobSquash;
  assign runElig   = (state == ST_IDLE) || (state == ST_RUN) || (state == ST_UNBLOCK);
  assign drainMode = (state == ST_UNBLOCK) && (skidCount != '0);
  assign haveWork  = drainMode || upValid;
  assign runEn     = runElig;

  always_comb begin
    nextState  = state;
    cmd        = '0;
    upStall    = 1'b0;
    issueValid = 1'b0;
    case (state)
      ST_IDLE, ST_RUN, ST_UNBLOCK: begin
        if (dnStall) begin
          nextState = ST_BLOCK;
          upStall   = 1'b1;
          cmd.push  = upValid;
        end else if (anySquash) begin
          nextState = ST_SQUASH;
          cmd.clear = 1'b1;
        end else if (iqFull && haveWork) begin
          nextState = ST_BLOCK;
          upStall   = 1'b1;
          cmd.push  = upValid;
        end else if (drainMode) begin
          cmd.pop     = 1'b1;
          cmd.selSkid = 1'b1;
          cmd.push    = upValid;
          issueValid  = 1'b1;
          upStall     = (skidCount > CNTW'(1));
          nextState   = (skidCount == CNTW'(1) && !upValid) ? ST_RUN : ST_UNBLOCK;
        end else begin
          issueValid = upValid;
          if (upValid || state == ST_UNBLOCK) nextState = ST_RUN;
        end
      end
      ST_BLOCK: begin
        upStall = 1'b1;
        if (anySquash) begin
          nextState = ST_SQUASH;
          cmd.clear = 1'b1;
        end else begin
          cmd.push = upValid;
          if (!dnStall && !iqFull) nextState = ST_UNBLOCK;
        end
      end
      ST_SQUASH: begin
        if (!anySquash) nextState = ST_RUN;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R3
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runElig && dnStall) |=> (state == ST_BLOCK));

  // R7
  squash_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((runElig || state == ST_BLOCK) && anySquash && !dnStall) |=> (state == ST_SQUASH));

  // R8
  squash_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SQUASH && anySquash) |=> (state == ST_SQUASH));

  // R10
  no_issue_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !issueValid);

  // R5
  block_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BLOCK && !anySquash && !dnStall && !iqFull) |=> (state == ST_UNBLOCK));

endmodule

// File: rtl/stall_squash_ctrl.sv
module stall_squash_ctrl
  import ssc_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int BUNDLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                upValid,
  input  logic [BUNDLE_W-1:0] upBundle,
  input  logic                dnStall,
  input  logic                dnSquash,
  input  logic                dnRobSquash,
  input  logic                iqFull,
  output logic                upStall,
  output logic                runEn,
  output logic                issueValid,
  output logic [BUNDLE_W-1:0] issueBundle,
  output logic [2:0]          status,
  output logic                overflowErr
);

  localparam int CNTW = $clog2(DEPTH + 1);

  skidCmd_t        cmd;
  logic [CNTW-1:0] skidCount;
  stageState_e     state;

  ssc_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .upValid(upValid), .dnStall(dnStall),
    .dnSquash(dnSquash), .dnRobSquash(dnRobSquash), .iqFull(iqFull),
    .skidCount(skidCount), .cmd(cmd), .upStall(upStall), .runEn(runEn),
    .issueValid(issueValid), .state(state)
  );

  ssc_skid #(.DEPTH(DEPTH), .BUNDLE_W(BUNDLE_W)) u_skid (
    .clk(clk), .rstN(rstN), .cmd(cmd), .upBundle(upBundle),
    .skidCount(skidCount), .issueBundle(issueBundle), .overflowErr(overflowErr)
  );

  assign status = state;

endmodule

// File: tb/stall_squash_ctrl_tb.sv
module stall_squash_ctrl_tb;

  localparam int W = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic upValid = 0, dnStall = 0, dnSquash = 0, dnRobSquash = 0, iqFull = 0;
  logic [W-1:0] upBundle = '0;
  logic upStall, runEn, issueValid, overflowErr;
  logic [W-1:0] issueBundle;
  logic [2:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stall_squash_ctrl #(.DEPTH(4), .BUNDLE_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .upValid(upValid), .upBundle(upBundle),
    .dnStall(dnStall), .dnSquash(dnSquash), .dnRobSquash(dnRobSquash),
    .iqFull(iqFull), .upStall(upStall), .runEn(runEn), .issueValid(issueValid),
    .issueBundle(issueBundle), .status(status), .overflowErr(overflowErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, settle, then checks may sample.
  task automatic setIn(input logic v, input int b, input logic st,
                       input logic sq, input logic rsq, input logic iq);
    @(negedge clk);
    upValid = v; upBundle = W'(b); dnStall = st;
    dnSquash = sq; dnRobSquash = rsq; iqFull = iq;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    setIn(0, 0, 0, 0, 0, 0);
    chk("R1 status", status, 0);
    chk("R1 runEn", runEn, 1);
    chk("R1 upStall", upStall, 0);
    chk("R1 overflowErr", overflowErr, 0);

    setIn(1, 'hA5, 0, 0, 0, 0);
    chk("R2 issueValid", issueValid, 1);
    chk("R2 issueBundle", issueBundle, 'hA5);
    chk("R2 upStall", upStall, 0);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R2 to Running", status, 1);

    // Sweep every fill level of the skid buffer
    for (int k = 1; k <= 4; k++) begin
      setIn(1, k*16, 1, 0, 0, 0);
      chk("R3 stall upStall", upStall, 1);
      chk("R3 no issue", issueValid, 0);
      for (int j = 1; j < k; j++) begin
        setIn(1, k*16 + j, 1, 0, 0, 0);
        chk("R5 blocked", status, 2);
        chk("R5 upStall", upStall, 1);
        chk("R10 runEn blocked", runEn, 0);
      end
      setIn(0, 0, 0, 0, 0, 0);
      chk("R5 still blocked", status, 2);
      chk("R5 upStall release cycle", upStall, 1);
      for (int j = 0; j < k; j++) begin
        setIn(0, 0, 0, 0, 0, 0);
        chk("R6 unblocking", status, 3);
        chk("R10 runEn unblocking", runEn, 1);
        chk("R6 replay valid", issueValid, 1);
        chk("R6 replay order", issueBundle, k*16 + j);
        chk("R6 upStall while entries", upStall, (j < k - 1) ? 1 : 0);
      end
      setIn(0, 0, 0, 0, 0, 0);
      chk("R6 back to Running", status, 1);
    end

    // Overfill by one
    for (int j = 0; j < 5; j++) setIn(1, 'h50 + j, 1, 0, 0, 0);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R9 overflowErr set", overflowErr, 1);
    for (int j = 0; j < 4; j++) begin
      setIn(0, 0, 0, 0, 0, 0);
      chk("R9 kept entries", issueBundle, 'h50 + j);
      chk("R9 replay valid", issueValid, 1);
    end
    setIn(0, 0, 0, 0, 0, 0);
    chk("R9 dropped bundle not replayed", status, 1);
    chk("R9 overflowErr sticky", overflowErr, 1);

    // Queue full
    setIn(0, 0, 0, 0, 0, 1);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R4 no work no block", status, 1);
    setIn(1, 'h60, 0, 0, 0, 1);
    chk("R4 iqFull no issue", issueValid, 0);
    chk("R4 iqFull upStall", upStall, 1);
    setIn(0, 0, 0, 0, 0, 1);
    chk("R4 blocked", status, 2);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R5 held by iqFull", status, 2);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R6 replay iq", issueBundle, 'h60);
    chk("R6 single entry upStall", upStall, 0);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R6 running", status, 1);

    // Squash from Running
    setIn(1, 'h70, 0, 1, 0, 0);
    chk("R7 squash suppresses issue", issueValid, 0);
    setIn(1, 'h71, 0, 1, 0, 0);
    chk("R8 squashing", status, 4);
    chk("R8 runEn", runEn, 0);
    chk("R8 upStall", upStall, 0);
    chk("R8 no issue", issueValid, 0);
    setIn(1, 'h72, 0, 0, 1, 0);
    chk("R8 rob squash holds", status, 4);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R8 still squashing", status, 4);
    setIn(1, 'h73, 0, 0, 0, 0);
    chk("R8 to Running", status, 1);
    chk("R8 dropped bundles gone", issueBundle, 'h73);

    // Stall beats squash; squash in Blocked clears the buffer
    setIn(1, 'h80, 1, 1, 0, 0);
    chk("R3 stall over squash", upStall, 1);
    setIn(0, 0, 0, 1, 0, 0);
    chk("R3 blocked", status, 2);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R7 squash from blocked", status, 4);
    setIn(1, 'h90, 1, 0, 0, 0);
    chk("R8 back to Running", status, 1);
    setIn(0, 0, 0, 0, 0, 0);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R7 buffer cleared", issueBundle, 'h90);
    chk("R7 single entry", upStall, 0);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R7 running", status, 1);

    // Stall in the middle of a drain
    setIn(1, 'hB0, 1, 0, 0, 0);
    setIn(1, 'hB1, 1, 0, 0, 0);
    setIn(0, 0, 0, 0, 0, 0);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R6 first pop", issueBundle, 'hB0);
    chk("R6 stall held", upStall, 1);
    setIn(0, 0, 1, 0, 0, 0);
    chk("R3 stall in unblocking", issueValid, 0);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R3 reblocked", status, 2);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R6 second pop", issueBundle, 'hB1);
    chk("R6 last pop upStall", upStall, 0);
    setIn(0, 0, 0, 0, 0, 0);
    chk("R6 final running", status, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule